// File: doc/BRIEF.md
# PWM Waveform Sample Sequencer

This block feeds fresh duty-cycle values to three PWM compare channels, one new value per PWM period. The timer raises a one-cycle strobe at the end of each period. In the following clock cycle the sequencer presents three 8-bit compare values, each with a write strobe, so that the timer's shadow registers are loaded before the counter wraps again. After external low-pass filtering, the three channels give a sinusoid, a sawtooth ramp and a steady level.

The sine channel reads a constant 32-entry table in order, using a 5-bit pointer. The ramp channel is an accumulator that adds a fixed step on every period and wraps, so it needs no table. The level channel repeats a constant that is captured from a configuration input while reset is held. With 256-count periods at an 8 kHz update rate, the sine runs at 250 Hz and the ramp at 125 Hz.

Top module: `pwm_wave_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all three write strobes are 0 and all three compare outputs are 0.
- R2: When `period_tick` is sampled high at a clock edge (with `rst` low), all three write strobes are 1 in the next cycle and in that cycle only. No write strobe rises unless `period_tick` was high at the edge before.
- R3: The k-th sine sample written after reset (k counted from 0) is entry k of a table whose entry i is round(128 + 127*sin(2*pi*i/32)). So the first four values are 128, 153, 177, 199, entry 8 is 255 and entry 24 is 1.
- R4: The sine table index wraps from 31 to 0. The 33rd sine write after reset is 128 again.
- R5: The first ramp sample written after reset is 0. Each later ramp sample is the previous one plus 4, modulo 256.
- R6: The ramp reaches 252 on its 64th write and returns to 0 on its 65th write, giving one ramp cycle per 64 periods.
- R7: The level channel writes the value that `dc_level_cfg` held during reset. Changes on `dc_level_cfg` after reset do not affect `dc_cmp`.
- R8: Between write strobes, each compare output holds its last value.
- R9: A `period_tick` that arrives while `rst` is high is ignored. The first tick after reset still produces sine 128 and ramp 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the level |
| period_tick | input | 1 | End-of-PWM-period strobe from the timer |
| dc_level_cfg | input | 8 | Level for the constant channel, captured during reset |
| sine_cmp | output | 8 | Sine channel compare value |
| sine_wr | output | 1 | Sine channel write strobe |
| ramp_cmp | output | 8 | Ramp channel compare value |
| ramp_wr | output | 1 | Ramp channel write strobe |
| dc_cmp | output | 8 | Level channel compare value |
| dc_wr | output | 1 | Level channel write strobe |

## Verification
The assertions check on every cycle that strobes follow ticks one-for-one, that compare outputs hold between strobes, that each ramp write is the previous one plus the step, and that the level never changes after its first write. The exact sine values, the wrap of the table pointer after 32 entries, the ramp wrap at 64 writes, and the effects of capture-at-reset and of ticks during reset can only be shown by the bench. It compares the outputs with a behavioural model on every clock, and it covers sparse ticks, back-to-back ticks and a second reset.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  localparam int SAMPLE_W  = 8;
  localparam int SINE_LEN  = 32;
  localparam int SINE_AW   = $clog2(SINE_LEN);
  localparam int CHAN_CNT  = 3;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [SINE_AW-1:0]  sine_idx_t;

  typedef enum logic [1:0] {
    CH_SINE = 2'd0,
    CH_RAMP = 2'd1,
    CH_DC   = 2'd2
  } chan_e;

  // One full sine cycle, mid-scale 128, amplitude 127.
  function automatic sample_t sine_rom(input sine_idx_t idx);
    sample_t v;
    case (idx)
      5'd0:  v = 8'd128;
      5'd1:  v = 8'd153;
      5'd2:  v = 8'd177;
      5'd3:  v = 8'd199;
      5'd4:  v = 8'd218;
      5'd5:  v = 8'd234;
      5'd6:  v = 8'd245;
      5'd7:  v = 8'd253;
      5'd8:  v = 8'd255;
      5'd9:  v = 8'd253;
      5'd10: v = 8'd245;
      5'd11: v = 8'd234;
      5'd12: v = 8'd218;
      5'd13: v = 8'd199;
      5'd14: v = 8'd177;
      5'd15: v = 8'd153;
      5'd16: v = 8'd128;
      5'd17: v = 8'd103;
      5'd18: v = 8'd79;
      5'd19: v = 8'd57;
      5'd20: v = 8'd38;
      5'd21: v = 8'd22;
      5'd22: v = 8'd11;
      5'd23: v = 8'd3;
      5'd24: v = 8'd1;
      5'd25: v = 8'd3;
      5'd26: v = 8'd11;
      5'd27: v = 8'd22;
      5'd28: v = 8'd38;
      5'd29: v = 8'd57;
      5'd30: v = 8'd79;
      default: v = 8'd103;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pwm_sine_walker.sv
module pwm_sine_walker
  import pwm_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    adv,
  output sample_t sample_q
);

  localparam sine_idx_t LAST_IDX = sine_idx_t'(SINE_LEN - 1);

  sine_idx_t ptr_q;

  // Registered ROM read: a synchronous read port suited to block RAM.
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      sample_q <= '0;
    end else if (adv) begin
      sample_q <= sine_rom(ptr_q);
      ptr_q    <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_ramp_accum.sv
module pwm_ramp_accum #(
  parameter int W    = 8,
  parameter int STEP = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] sample_q
);

  localparam logic [W-1:0] STEP_V = W'(STEP);

  logic [W-1:0] acc_q;

  // The W-bit sum wraps on its own once it passes full scale.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      sample_q <= '0;
    end else if (adv) begin
      sample_q <= acc_q;
      acc_q    <= acc_q + STEP_V;
    end
  end

endmodule

// File: rtl/pwm_dc_hold.sv
module pwm_dc_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] level_cfg,
  output logic [W-1:0] sample_q
);

  logic [W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= level_cfg;
      sample_q <= '0;
    end else if (adv) begin
      sample_q <= level_q;
    end
  end

endmodule

// File: rtl/pwm_wave_seq.sv
module pwm_wave_seq
  import pwm_seq_pkg::*;
#(
  parameter int RAMP_STEP = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                period_tick,
  input  logic [SAMPLE_W-1:0] dc_level_cfg,
  output logic [SAMPLE_W-1:0] sine_cmp,
  output logic                sine_wr,
  output logic [SAMPLE_W-1:0] ramp_cmp,
  output logic                ramp_wr,
  output logic [SAMPLE_W-1:0] dc_cmp,
  output logic                dc_wr
);

  logic [CHAN_CNT-1:0] wr_q;

  // One registered strobe per channel, aligned with its sample register.
  for (genvar c = 0; c < CHAN_CNT; c++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) wr_q[c] <= 1'b0;
      else     wr_q[c] <= period_tick;
    end
  end

  pwm_sine_walker u_sine (
    .clk      (clk),
    .rst      (rst),
    .adv      (period_tick),
    .sample_q (sine_cmp)
  );

  pwm_ramp_accum #(.W(SAMPLE_W), .STEP(RAMP_STEP)) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .adv      (period_tick),
    .sample_q (ramp_cmp)
  );

  pwm_dc_hold #(.W(SAMPLE_W)) u_dc (
    .clk       (clk),
    .rst       (rst),
    .adv       (period_tick),
    .level_cfg (dc_level_cfg),
    .sample_q  (dc_cmp)
  );

  assign sine_wr = wr_q[CH_SINE];
  assign ramp_wr = wr_q[CH_RAMP];
  assign dc_wr   = wr_q[CH_DC];

endmodule

// File: rtl/pwm_wave_seq_chk.sv
module pwm_wave_seq_chk #(
  parameter int W    = 8,
  parameter int STEP = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         period_tick,
  input logic [W-1:0] sine_cmp,
  input logic         sine_wr,
  input logic [W-1:0] ramp_cmp,
  input logic         ramp_wr,
  input logic [W-1:0] dc_cmp,
  input logic         dc_wr
);

  logic         past_ok, ramp_seen, dc_seen;
  logic [W-1:0] last_ramp, dc_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok   <= 1'b0;
      ramp_seen <= 1'b0;
      dc_seen   <= 1'b0;
      last_ramp <= '0;
      dc_ref    <= '0;
    end else begin
      past_ok <= 1'b1;
      if (ramp_wr) begin
        ramp_seen <= 1'b1;
        last_ramp <= ramp_cmp;
      end
      if (dc_wr && !dc_seen) begin
        dc_seen <= 1'b1;
        dc_ref  <= dc_cmp;
      end
    end
  end

  a_r2_wr_after_tick: assert property (@(posedge clk) disable iff (rst)
    period_tick |=> (sine_wr && ramp_wr && dc_wr));

  a_r2_no_spurious_wr: assert property (@(posedge clk) disable iff (rst)
    !period_tick |=> (!sine_wr && !ramp_wr && !dc_wr));

  a_r8_sine_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !sine_wr) |-> $stable(sine_cmp));

  a_r8_ramp_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !ramp_wr) |-> $stable(ramp_cmp));

  a_r8_dc_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !dc_wr) |-> $stable(dc_cmp));

  a_r5_ramp_first_zero: assert property (@(posedge clk) disable iff (rst)
    (ramp_wr && !ramp_seen) |-> (ramp_cmp == '0));

  a_r5_ramp_step: assert property (@(posedge clk) disable iff (rst)
    (ramp_wr && ramp_seen) |-> (ramp_cmp == W'(last_ramp + W'(STEP))));

  a_r7_dc_constant: assert property (@(posedge clk) disable iff (rst)
    (dc_wr && dc_seen) |-> (dc_cmp == dc_ref));

endmodule

bind pwm_wave_seq pwm_wave_seq_chk #(.W(pwm_seq_pkg::SAMPLE_W), .STEP(RAMP_STEP)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .period_tick (period_tick),
  .sine_cmp    (sine_cmp),
  .sine_wr     (sine_wr),
  .ramp_cmp    (ramp_cmp),
  .ramp_wr     (ramp_wr),
  .dc_cmp      (dc_cmp),
  .dc_wr       (dc_wr)
);

// File: tb/pwm_wave_seq_tb_top.sv
module pwm_wave_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       period_tick = 1'b0;
  logic [7:0] dc_level_cfg = 8'd170;
  logic [7:0] sine_cmp, ramp_cmp, dc_cmp;
  logic       sine_wr, ramp_wr, dc_wr;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_wave_seq dut_i (
    .clk          (clk),
    .rst          (rst),
    .period_tick  (period_tick),
    .dc_level_cfg (dc_level_cfg),
    .sine_cmp     (sine_cmp),
    .sine_wr      (sine_wr),
    .ramp_cmp     (ramp_cmp),
    .ramp_wr      (ramp_wr),
    .dc_cmp       (dc_cmp),
    .dc_wr        (dc_wr)
  );

  // Behavioural reference model, advanced at each rising edge.
  int m_idx = 0, m_acc = 0, m_lvl = 0;
  int e_sine = 0, e_ramp = 0, e_dc = 0, e_wr = 0;

  function automatic int sine_ref(input int i);
    real v;
    v = 128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * i / 32.0);
    return int'(v);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_idx = 0; m_acc = 0; m_lvl = dc_level_cfg;
      e_sine = 0; e_ramp = 0; e_dc = 0; e_wr = 0;
    end else begin
      e_wr = period_tick ? 1 : 0;
      if (period_tick) begin
        e_sine = sine_ref(m_idx);
        m_idx  = (m_idx + 1) % 32;
        e_ramp = m_acc;
        m_acc  = (m_acc + 4) % 256;
        e_dc   = m_lvl;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the rising edge.
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 sine_wr", sine_wr, e_wr);
      chk("R2 ramp_wr", ramp_wr, e_wr);
      chk("R2 dc_wr", dc_wr, e_wr);
      chk("R3 R4 R8 sine_cmp", sine_cmp, e_sine);
      chk("R5 R6 R8 ramp_cmp", ramp_cmp, e_ramp);
      chk("R7 R8 dc_cmp", dc_cmp, e_dc);
    end
  end

  task automatic pulse(input int gap);
    period_tick = 1'b1;
    @(negedge clk);
    period_tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sine", sine_cmp, 0);
    chk("R1 reset wr", sine_wr | ramp_wr | dc_wr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", ramp_cmp + dc_cmp, 0);

    // Sparse ticks; check the first values at the cycle after each tick.
    pulse(0);
    chk("R3 first sine", sine_cmp, 128);
    chk("R5 first ramp", ramp_cmp, 0);
    chk("R7 dc level", dc_cmp, 170);
    repeat (2) @(negedge clk);
    chk("R8 hold after tick", sine_cmp, 128);
    pulse(3);
    chk("R3 second sine", sine_cmp, 153);
    dc_level_cfg = 8'd17;
    for (int n = 3; n <= 33; n++) begin
      pulse(0);
      if (n == 9)  chk("R3 sine peak", sine_cmp, 255);
      if (n == 25) chk("R3 sine trough", sine_cmp, 1);
      if (n == 33) chk("R4 sine wrap", sine_cmp, 128);
      repeat (n % 4) @(negedge clk);
    end
    chk("R7 cfg ignored after reset", dc_cmp, 170);

    // Back-to-back ticks through the ramp wrap.
    period_tick = 1'b1;
    for (int n = 34; n <= 66; n++) begin
      @(negedge clk);
      if (n == 64) chk("R6 ramp top", ramp_cmp, 252);
      if (n == 65) chk("R6 ramp wrap", ramp_cmp, 0);
    end
    period_tick = 1'b0;
    repeat (3) @(negedge clk);

    // Second reset with a tick during reset and a new level.
    rst = 1'b1;
    dc_level_cfg = 8'd60;
    @(negedge clk);
    period_tick = 1'b1;
    @(negedge clk);
    period_tick = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    pulse(1);
    chk("R9 sine after reset", sine_cmp, 128);
    chk("R9 ramp after reset", ramp_cmp, 0);
    chk("R7 new level", dc_cmp, 60);
    for (int n = 0; n < 10; n++) pulse(n % 3);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule